// File: doc/BRIEF.md
# Memory-Mapped Address Space Decoder

This block joins three storage regions behind one address bus: a data RAM, a framebuffer RAM and a one-word keyboard register. A client drives an address, write data and a load strobe, and gets back the word that the address points at. The load strobe reaches only the region that the address selects. Addresses above the keyboard word belong to no region. They read as zero and raise an invalid flag.

The region sizes are set by two parameters. `RAM_AW` is the data RAM address width and `FB_AW` is the framebuffer address width, with `FB_AW < RAM_AW`. The address is `RAM_AW+1` bits wide. The data RAM sits at 0 to 2^RAM_AW-1. The framebuffer follows at 2^RAM_AW to 2^RAM_AW+2^FB_AW-1. The keyboard word sits at 2^RAM_AW+2^FB_AW. For `RAM_AW=14` and `FB_AW=13` this gives data RAM at 0..16383, framebuffer at 16384..24575 and keyboard at 24576, in a 15-bit space. The defaults are scaled down to `RAM_AW=8` and `FB_AW=7`: RAM at 0..255, framebuffer at 256..383, keyboard at 384, and 385..511 invalid.

Both RAMs write on the rising clock edge and read combinationally. The keyboard register loads the external scan code on every clock edge. That code is 0 when no key is pressed.

Top module: `mmap_space`

## Requirements
- R1: An address below 2^RAM_AW reads and writes data RAM word `addr`.
- R2: An address from 2^RAM_AW to 2^RAM_AW+2^FB_AW-1 reads and writes framebuffer word `addr - 2^RAM_AW`, taken from the low FB_AW address bits. The framebuffer is storage separate from the data RAM.
- R3: The keyboard address returns the scan code `key_code_i` sampled at the latest rising edge. After reset it returns 0 until the first edge.
- R4: Any address above the keyboard address returns `rdata_o` = 0 with `invalid_o` = 1. On every other address `invalid_o` = 0.
- R5: A write with `load_i` = 1 takes effect at the rising edge. The read is combinational, so a read of the written address in the write cycle returns the old word, and the new word appears after the edge.
- R6: With `load_i` = 0, no stored word changes.
- R7: A write to the keyboard address is ignored: the register keeps following `key_code_i`, and no RAM word changes.
- R8: A write to an invalid address changes no stored word.
- R9: A write into one RAM region leaves every word of the other region unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset (keyboard register only) |
| addr_i | input | RAM_AW+1 | Word address |
| wdata_i | input | DW | Write data |
| load_i | input | 1 | Write strobe, applied at the rising edge |
| key_code_i | input | DW | Scan code of the pressed key, 0 for none |
| rdata_o | output | DW | Addressed word, combinational |
| invalid_o | output | 1 | Address lies outside every region |

## Verification
Two events can fall in the same cycle, and the bench provokes each pair deliberately.

The first pair is a write and a read of the same word. The bench holds a RAM write pending, samples `rdata_o` before the edge and expects the old word, then samples again after the edge and expects the new one.

The second pair is a scan-code change and a write to the keyboard address. The bench presents both at once. After the edge it expects the keyboard word to show the new scan code, not the written data.

Full sweeps over all 512 addresses then confirm two things against a bench-side model of both RAMs. Neither the keyboard write nor any invalid-address write has disturbed a stored word. No write in one region has reached the other.

// File: rtl/mmap_pkg.sv
package mmap_pkg;
  typedef enum logic [1:0] {
    RGN_RAM  = 2'd0,
    RGN_FB   = 2'd1,
    RGN_KBD  = 2'd2,
    RGN_NONE = 2'd3
  } rgn_e;
endpackage

// File: rtl/mmap_decode.sv
module mmap_decode
  import mmap_pkg::*;
#(
  parameter int unsigned RAM_AW = 8,
  parameter int unsigned FB_AW  = 7,
  localparam int unsigned ADDR_W = RAM_AW + 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output rgn_e              rgn_o,
  output logic [RAM_AW-1:0] ram_idx_o,
  output logic [FB_AW-1:0]  fb_idx_o
);
  // offset of the keyboard word above the RAM region
  localparam logic [RAM_AW-1:0] KBD_OFF = RAM_AW'(1) << FB_AW;

  logic [RAM_AW-1:0] upper;
  logic              fb_hit;

  assign upper     = addr_i[RAM_AW-1:0];
  assign ram_idx_o = addr_i[RAM_AW-1:0];
  assign fb_idx_o  = addr_i[FB_AW-1:0];
  assign fb_hit    = (upper >> FB_AW) == '0;

  always_comb begin
    if (!addr_i[ADDR_W-1])     rgn_o = RGN_RAM;
    else if (fb_hit)           rgn_o = RGN_FB;
    else if (upper == KBD_OFF) rgn_o = RGN_KBD;
    else                       rgn_o = RGN_NONE;
  end
endmodule

// File: rtl/mmap_ram.sv
module mmap_ram #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 16,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/mmap_kbd_reg.sv
module mmap_kbd_reg #(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] code_i,
  output logic [DW-1:0] code_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) code_o <= '0;
    else         code_o <= code_i;
  end
endmodule

// File: rtl/mmap_space.sv
module mmap_space
  import mmap_pkg::*;
#(
  parameter int unsigned RAM_AW = 8,
  parameter int unsigned FB_AW  = 7,
  parameter int unsigned DW     = 16,
  localparam int unsigned ADDR_W = RAM_AW + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              load_i,
  input  logic [DW-1:0]     key_code_i,
  output logic [DW-1:0]     rdata_o,
  output logic              invalid_o
);
  rgn_e              rgn;
  logic [RAM_AW-1:0] ram_idx;
  logic [FB_AW-1:0]  fb_idx;
  logic [DW-1:0]     ram_rd, fb_rd, kbd_rd;
  logic              ram_we, fb_we;

  mmap_decode #(.RAM_AW(RAM_AW), .FB_AW(FB_AW)) u_dec (
    .addr_i   (addr_i),
    .rgn_o    (rgn),
    .ram_idx_o(ram_idx),
    .fb_idx_o (fb_idx)
  );

  // strobe reaches only the selected array
  assign ram_we = load_i && (rgn == RGN_RAM);
  assign fb_we  = load_i && (rgn == RGN_FB);

  mmap_ram #(.AW(RAM_AW), .DW(DW)) u_ram (
    .clk_i  (clk_i),
    .we_i   (ram_we),
    .addr_i (ram_idx),
    .wdata_i(wdata_i),
    .rdata_o(ram_rd)
  );

  mmap_ram #(.AW(FB_AW), .DW(DW)) u_fb (
    .clk_i  (clk_i),
    .we_i   (fb_we),
    .addr_i (fb_idx),
    .wdata_i(wdata_i),
    .rdata_o(fb_rd)
  );

  mmap_kbd_reg #(.DW(DW)) u_kbd (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .code_i(key_code_i),
    .code_o(kbd_rd)
  );

  always_comb begin
    rdata_o   = '0;
    invalid_o = 1'b0;
    case (rgn)
      RGN_RAM: rdata_o   = ram_rd;
      RGN_FB:  rdata_o   = fb_rd;
      RGN_KBD: rdata_o   = kbd_rd;
      default: invalid_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/mmap_space_chk.sv
module mmap_space_chk #(
  parameter int unsigned RAM_AW = 8,
  parameter int unsigned FB_AW  = 7,
  parameter int unsigned DW     = 16,
  localparam int unsigned ADDR_W = RAM_AW + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DW-1:0]     wdata_i,
  input logic              load_i,
  input logic [DW-1:0]     key_code_i,
  input logic [DW-1:0]     rdata_o,
  input logic              invalid_o
);
  localparam logic [ADDR_W-1:0] KBD_ADDR =
    (ADDR_W'(1) << RAM_AW) | (ADDR_W'(1) << FB_AW);

  logic armed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  // R4
  invalid_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    invalid_o |-> rdata_o == '0);

  // R4
  invalid_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    invalid_o == (addr_i > KBD_ADDR));

  // R3
  kbd_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && addr_i == KBD_ADDR) |-> rdata_o == $past(key_code_i));

  // R5
  write_land_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && addr_i < KBD_ADDR) |=>
      (addr_i != $past(addr_i) || rdata_o == $past(wdata_i)));

  // R6
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && !$past(load_i) && $stable(addr_i) && addr_i != KBD_ADDR)
      |-> $stable(rdata_o));
endmodule

bind mmap_space mmap_space_chk #(.RAM_AW(RAM_AW), .FB_AW(FB_AW), .DW(DW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .load_i    (load_i),
  .key_code_i(key_code_i),
  .rdata_o   (rdata_o),
  .invalid_o (invalid_o)
);

// File: tb/tb_mmap_space.sv
module tb_mmap_space;
  localparam int RAM_AW = 8;
  localparam int FB_AW  = 7;
  localparam int DW     = 16;
  localparam int AW     = RAM_AW + 1;
  localparam int FB_BASE = 1 << RAM_AW;
  localparam int KBD     = FB_BASE + (1 << FB_AW);
  localparam int SPAN    = 1 << AW;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic          load_i = 1'b0;
  logic [DW-1:0] key_code_i = '0;
  logic [DW-1:0] rdata_o;
  logic          invalid_o;

  int n_chk = 0;
  int n_err = 0;
  logic [DW-1:0] model [KBD];
  logic [DW-1:0] kbd_exp;

  always #2 clk_i = ~clk_i;

  mmap_space #(.RAM_AW(RAM_AW), .FB_AW(FB_AW), .DW(DW)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .load_i(load_i), .key_code_i(key_code_i), .rdata_o(rdata_o),
    .invalid_o(invalid_o)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int a, input int s);
    return DW'(a * 97 + s * 1231) ^ DW'(a << 7) ^ DW'(s << 12);
  endfunction

  // writes are launched at a negedge and land on the next posedge
  task automatic wr(input int a, input logic [DW-1:0] d);
    addr_i = AW'(a); wdata_i = d; load_i = 1'b1;
    @(negedge clk_i);
    load_i = 1'b0;
  endtask

  task automatic sweep();
    for (int a = 0; a < SPAN; a++) begin
      addr_i = AW'(a);
      #1;
      if (a < FB_BASE) begin
        chk("R1", rdata_o, model[a]);
        chk("R4", {15'd0, invalid_o}, 16'd0);
      end else if (a < KBD) begin
        chk("R2", rdata_o, model[a]);
        chk("R4", {15'd0, invalid_o}, 16'd0);
      end else if (a == KBD) begin
        chk("R3", rdata_o, kbd_exp);
        chk("R4", {15'd0, invalid_o}, 16'd0);
      end else begin
        chk("R4", rdata_o, 16'd0);
        chk("R4", {15'd0, invalid_o}, 16'd1);
      end
      @(negedge clk_i);
    end
  endtask

  task automatic fill(input int s);
    for (int a = 0; a < KBD; a++) begin
      wr(a, pat(a, s));
      model[a] = pat(a, s);
    end
  endtask

  initial begin
    #(4 * 200000);
    n_err++;
    $display("FAIL watchdog act=running exp=done");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    key_code_i = 16'h00ab;
    addr_i = AW'(KBD);
    #1;
    chk("R3", rdata_o, 16'd0);               // reset value
    addr_i = AW'(KBD + 1);
    #1;
    chk("R4", {15'd0, invalid_o}, 16'd1);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    kbd_exp = 16'h00ab;

    fill(1);
    sweep();

    // R6: data on the bus without load
    addr_i = AW'(5); wdata_i = 16'hffff; load_i = 1'b0;
    @(negedge clk_i); @(negedge clk_i);
    #1 chk("R6", rdata_o, model[5]);
    addr_i = AW'(FB_BASE + 3);
    @(negedge clk_i);
    #1 chk("R6", rdata_o, model[FB_BASE + 3]);
    @(negedge clk_i);

    // R7: write to keyboard word is dropped
    wr(KBD, 16'h1234);
    addr_i = AW'(KBD);
    #1 chk("R7", rdata_o, 16'h00ab);
    @(negedge clk_i);
    // R8: writes across every invalid address
    for (int a = KBD + 1; a < SPAN; a++) wr(a, 16'hdead ^ DW'(a));
    sweep();

    // R9: adjacent-index writes in each region
    wr(FB_BASE + 10, 16'hbeef); model[FB_BASE + 10] = 16'hbeef;
    addr_i = AW'(10);
    #1 chk("R9", rdata_o, model[10]);
    @(negedge clk_i);
    wr(10, 16'hcafe); model[10] = 16'hcafe;
    addr_i = AW'(FB_BASE + 10);
    #1 chk("R9", rdata_o, 16'hbeef);
    @(negedge clk_i);

    fill(2);
    sweep();

    // R5: read during write returns old word until the edge
    addr_i = AW'(7); wdata_i = 16'h5a5a; load_i = 1'b1;
    #1 chk("R5", rdata_o, model[7]);
    @(posedge clk_i);
    #1 chk("R5", rdata_o, 16'h5a5a);
    model[7] = 16'h5a5a;
    @(negedge clk_i);
    load_i = 1'b0;
    addr_i = AW'(FB_BASE + 100); wdata_i = 16'h0f0f; load_i = 1'b1;
    #1 chk("R5", rdata_o, model[FB_BASE + 100]);
    @(posedge clk_i);
    #1 chk("R5", rdata_o, 16'h0f0f);
    model[FB_BASE + 100] = 16'h0f0f;
    @(negedge clk_i);
    load_i = 1'b0;

    // R3: scan code tracking
    addr_i = AW'(KBD); key_code_i = 16'h0041;
    #1 chk("R3", rdata_o, 16'h00ab);
    @(negedge clk_i);
    #1 chk("R3", rdata_o, 16'h0041);
    key_code_i = 16'h0000;
    @(negedge clk_i);
    #1 chk("R3", rdata_o, 16'h0000);
    // R7: scan-code change and keyboard write in the same cycle
    key_code_i = 16'h0077;
    wr(KBD, 16'h0099);
    #1 chk("R7", rdata_o, 16'h0077);
    kbd_exp = 16'h0077;
    @(negedge clk_i);
    sweep();

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule